// File: doc/BRIEF.md
# Oversampled Serial Packet Receiver

This block takes a single-wire serial line that is not phase-locked to the local clock and recovers packets from it. The line rests low. A packet begins with a rising edge, which is the start bit. The bit after the start bit gives the packet type. A low second bit marks a two-bit acknowledge packet. A high second bit marks a data packet: eight payload bits follow, least significant first, and then a low stop bit.

The line first passes through a flop synchroniser. It is then examined at a fixed oversampling rate. The phase count starts from the sample where the start edge is seen, and each bit is taken near the middle of its cell. A data packet yields the byte and a one-cycle valid strobe. An acknowledge packet yields a one-cycle acknowledge-seen pulse, which goes to the local transmitter and never reaches the data output. If the stop bit is sampled high, the block drops the byte, pulses a framing-error flag and ignores the line until it falls low again.

A static rate select picks one of two oversampling tick dividers, so one build serves both the standard bit rate and the double rate.

Top module: `serlink_rx`

## Requirements
- R1: After reset, `rx_valid`, `ack_seen` and `frame_err` are low and `rx_byte` reads 0x00.
- R2: A data packet (1, 1, eight payload bits LSB first, 0) drives `rx_byte` to the payload and pulses `rx_valid` for exactly one cycle, once per packet.
- R3: An acknowledge packet (1 then 0) pulses `ack_seen` for exactly one cycle and produces no `rx_valid` pulse.
- R4: A data packet whose stop bit is high pulses `frame_err` once and gives no `rx_valid`. `rx_byte` keeps its previous value. While the line stays high afterwards, no new packet is started.
- R5: A high pulse on the line that is shorter than half a bit and has ended before the start-bit mid-sample is ignored: no pulse appears on any output.
- R6: The `rx_valid` pulse of a data packet arrives less than 14 bit times after the start edge appears at `line_in`.
- R7: With `fast_rate` high, the bit time is half of the one used with `fast_rate` low (16 clocks against 32 clocks with default parameters). The same framing rules then apply.
- R8: At the slow rate, packets whose bit cells are 1/32 longer or shorter than nominal are still received correctly.
- R9: At most one of `rx_valid`, `ack_seen`, `frame_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| fast_rate | input | 1 | Static rate select: 1 selects the double bit rate |
| line_in | input | 1 | Asynchronous serial line, idle low |
| rx_byte | output | DATA_W | Last byte received correctly |
| rx_valid | output | 1 | One-cycle strobe: `rx_byte` was just updated |
| ack_seen | output | 1 | One-cycle pulse: an acknowledge packet arrived |
| frame_err | output | 1 | One-cycle pulse: the stop bit was high and the byte was dropped |

## Verification
The bench uses the default parameters: 8x oversampling, two synchroniser stages, and tick dividers of 4 and 2 clocks. These give bit cells of 32 and 16 clocks. A 32-clock cell is long enough for a driven cell of 31 or 33 clocks to move the mid-sample point by ten clocks across a packet. That drift sits inside the sampling margin, so the tolerance requirement can be exercised directly. The 16-clock cell exercises the rate select. The table walk covers a mix of data, acknowledge and framing-error packets. Directed tests add a sub-half-bit glitch and the rate switch.

// File: rtl/serlink_rx_pkg.sv
package serlink_rx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RECV = 2'd1,
      ST_HOLD = 2'd2
   } rx_state_t;
endpackage

// File: rtl/serlink_rx_sync.sv
module serlink_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      genvar g;
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/serlink_rx_tick.sv
module serlink_rx_tick #(
   parameter int DIV_SLOW = 4,
   parameter int DIV_FAST = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast_sel,
   output logic tick
);
   localparam int MAXDIV = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
   localparam int CW     = $clog2(MAXDIV + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   assign limit = fast_sel ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
   assign tick  = (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   generate
      if (DIV_FAST > 1) begin : g_fast_gap
         AST_FAST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (fast_sel && $stable(fast_sel) && tick) |=> !tick); // R7
      end
      if (DIV_SLOW > 1) begin : g_slow_gap
         AST_SLOW_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (!fast_sel && $stable(fast_sel) && tick) |=> !tick); // R7
      end
   endgenerate
endmodule

// File: rtl/serlink_rx_frame.sv
module serlink_rx_frame
   import serlink_rx_pkg::*;
#(
   parameter int OSR    = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   output logic [DATA_W-1:0] data,
   output logic              data_vld,
   output logic              ack_pls,
   output logic              ferr_pls
);
   localparam int NBITS    = DATA_W + 3;
   localparam int STOP_IDX = DATA_W + 2;
   localparam int PH_W     = $clog2(OSR);
   localparam int BN_W     = $clog2(NBITS);
   localparam int MID      = OSR / 2 - 2;

   rx_state_t         state;
   logic [PH_W-1:0]   ph;
   logic [BN_W-1:0]   bitn;
   logic              prev;
   logic [DATA_W-1:0] shreg;
   logic              at_mid;

   assign at_mid = tick && (ph == PH_W'(MID));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ph       <= '0;
         bitn     <= '0;
         prev     <= 1'b0;
         shreg    <= '0;
         data     <= '0;
         data_vld <= 1'b0;
         ack_pls  <= 1'b0;
         ferr_pls <= 1'b0;
      end else begin
         data_vld <= 1'b0;
         ack_pls  <= 1'b0;
         ferr_pls <= 1'b0;
         if (tick) begin
            case (state)
               ST_IDLE: begin
                  prev <= line;
                  if (line && !prev) begin
                     state <= ST_RECV;
                     ph    <= '0;
                     bitn  <= '0;
                  end
               end
               ST_RECV: begin
                  if (ph == PH_W'(OSR - 1)) ph <= '0;
                  else                      ph <= ph + 1'b1;
                  if (at_mid) begin
                     bitn <= bitn + 1'b1;
                     if (bitn == '0) begin
                        if (!line) begin
                           state <= ST_IDLE;
                           prev  <= 1'b0;
                        end
                     end else if (bitn == BN_W'(1)) begin
                        if (!line) begin
                           ack_pls <= 1'b1;
                           state   <= ST_IDLE;
                           prev    <= 1'b0;
                        end
                     end else if (bitn == BN_W'(STOP_IDX)) begin
                        if (!line) begin
                           data     <= shreg;
                           data_vld <= 1'b1;
                           state    <= ST_IDLE;
                           prev     <= 1'b0;
                        end else begin
                           ferr_pls <= 1'b1;
                           state    <= ST_HOLD;
                        end
                     end else begin
                        shreg <= {line, shreg[DATA_W-1:1]};
                     end
                  end
               end
               ST_HOLD: begin
                  if (!line) begin
                     state <= ST_IDLE;
                     prev  <= 1'b0;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({data_vld, ack_pls, ferr_pls})); // R9
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      data_vld |=> !data_vld); // R2
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_pls |=> !ack_pls); // R3
   AST_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data) |-> data_vld); // R4
   AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD) |=> (!data_vld && !ack_pls)); // R4
   AST_ERR_NEEDS_RECV: assert property (@(posedge clk) disable iff (!rst_n)
      ferr_pls |-> $past(state == ST_RECV)); // R4
endmodule

// File: rtl/serlink_rx.sv
module serlink_rx #(
   parameter int OSR         = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_SLOW    = 4,
   parameter int DIV_FAST    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_rate,
   input  logic              line_in,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              ack_seen,
   output logic              frame_err
);
   generate
      if (OSR < 4) begin : g_bad_osr
         $error("serlink_rx: OSR must be at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serlink_rx: SYNC_STAGES must be at least 2");
      end
      if (DIV_SLOW < 1 || DIV_FAST < 1) begin : g_bad_div
         $error("serlink_rx: tick dividers must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("serlink_rx: DATA_W must be at least 1");
      end
   endgenerate

   logic line_s;
   logic tick;

   serlink_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (line_in),
      .q_sync  (line_s)
   );

   serlink_rx_tick #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) i_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .fast_sel (fast_rate),
      .tick     (tick)
   );

   serlink_rx_frame #(.OSR(OSR), .DATA_W(DATA_W)) i_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .line     (line_s),
      .data     (rx_byte),
      .data_vld (rx_valid),
      .ack_pls  (ack_seen),
      .ferr_pls (frame_err)
   );

   AST_ACK_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ack_seen |-> !rx_valid); // R3
endmodule

// File: tb/test_serlink_rx.sv
module test_serlink_rx;
   localparam int SLOW_BIT = 32;
   localparam int FAST_BIT = 16;
   localparam int WD_LIMIT = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fast_rate = 1'b0;
   logic       line_in = 1'b0;
   logic [7:0] rx_byte;
   logic       rx_valid, ack_seen, frame_err;

   int checks = 0, errors = 0;
   int cyc = 0, n_vld = 0, n_ack = 0, n_ferr = 0;
   int t_start = 0, t_vld = 0;
   logic [7:0] last_byte = 8'h00;

   always #2 clk = ~clk;

   serlink_rx i_serlink_rx (
      .clk(clk), .rst_n(rst_n), .fast_rate(fast_rate), .line_in(line_in),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .ack_seen(ack_seen), .frame_err(frame_err)
   );

   // kind in [9:8]: 0 data, 1 acknowledge, 2 data with high stop bit
   localparam logic [9:0] VEC [8] = '{
      {2'd0, 8'hA5}, {2'd1, 8'h00}, {2'd0, 8'h00}, {2'd0, 8'hFF},
      {2'd2, 8'h3C}, {2'd0, 8'h81}, {2'd1, 8'h00}, {2'd0, 8'h5A}
   };

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rx_valid) begin
         n_vld <= n_vld + 1;
         last_byte <= rx_byte;
         t_vld <= cyc;
      end
      if (ack_seen)  n_ack  <= n_ack + 1;
      if (frame_err) n_ferr <= n_ferr + 1;
      if (cyc > WD_LIMIT) begin
         errors = errors + 1;
         $display("FAIL watchdog expired: act %0d cycles exp below %0d", cyc, WD_LIMIT);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
      end
   endtask

   task automatic drive_bits(input int n, input logic [15:0] v, input int per);
      for (int i = 0; i < n; i++) begin
         line_in = v[i];
         repeat (per) @(negedge clk);
      end
      line_in = 1'b0;
   endtask

   task automatic send_pkt(input logic [1:0] kind, input logic [7:0] b, input int per);
      t_start = cyc;
      case (kind)
         2'd0: drive_bits(11, {5'b0, 1'b0, b, 1'b1, 1'b1}, per);
         2'd1: drive_bits(2, 16'b01, per);
         default: begin
            drive_bits(11, {5'b0, 1'b1, b, 1'b1, 1'b1}, per);
            line_in = 1'b1;
            repeat (3 * per) @(negedge clk);
            line_in = 1'b0;
         end
      endcase
      repeat (6 * per) @(negedge clk);
   endtask

   task automatic run_pkt(input logic [1:0] kind, input logic [7:0] b, input int per);
      int v0, a0, f0;
      logic [7:0] old;
      v0 = n_vld; a0 = n_ack; f0 = n_ferr; old = last_byte;
      send_pkt(kind, b, per);
      case (kind)
         2'd0: begin
            check(n_vld == v0 + 1, "R2 valid count", n_vld - v0, 1);
            check(last_byte == b, "R2 byte", last_byte, b);
            check(t_vld - t_start < 14 * per, "R6 latency", t_vld - t_start, 14 * per);
            check(n_ack == a0 && n_ferr == f0, "R9 other pulses", n_ack + n_ferr, a0 + f0);
         end
         2'd1: begin
            check(n_ack == a0 + 1, "R3 ack count", n_ack - a0, 1);
            check(n_vld == v0, "R3 no data", n_vld - v0, 0);
         end
         default: begin
            check(n_ferr == f0 + 1, "R4 error count", n_ferr - f0, 1);
            check(n_vld == v0 && n_ack == a0, "R4 no delivery", n_vld + n_ack, v0 + a0);
            check(rx_byte == old, "R4 byte kept", rx_byte, old);
         end
      endcase
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      // R1 reset state
      check(!rx_valid && !ack_seen && !frame_err, "R1 pulses low",
            {rx_valid, ack_seen, frame_err}, 0);
      check(rx_byte == 8'h00, "R1 byte zero", rx_byte, 0);
      check(n_vld == 0 && n_ack == 0 && n_ferr == 0, "R1 no pulse", n_vld + n_ack + n_ferr, 0);

      for (int k = 0; k < 8; k++) run_pkt(VEC[k][9:8], VEC[k][7:0], SLOW_BIT);

      // R5 short glitch
      begin
         int v0, a0, f0;
         v0 = n_vld; a0 = n_ack; f0 = n_ferr;
         line_in = 1'b1;
         repeat (6) @(negedge clk);
         line_in = 1'b0;
         repeat (12 * SLOW_BIT) @(negedge clk);
         check(n_vld == v0 && n_ack == a0 && n_ferr == f0, "R5 glitch ignored",
               (n_vld - v0) + (n_ack - a0) + (n_ferr - f0), 0);
      end
      run_pkt(2'd0, 8'h96, SLOW_BIT);

      // R8 bit cells off nominal by one clock in 32
      run_pkt(2'd0, 8'hC3, SLOW_BIT - 1);
      run_pkt(2'd0, 8'h69, SLOW_BIT + 1);
      run_pkt(2'd1, 8'h00, SLOW_BIT + 1);

      // R7 double rate
      fast_rate = 1'b1;
      repeat (20) @(negedge clk);
      run_pkt(2'd0, 8'h3C, FAST_BIT);
      run_pkt(2'd1, 8'h00, FAST_BIT);
      run_pkt(2'd2, 8'hE7, FAST_BIT);
      run_pkt(2'd0, 8'h12, FAST_BIT);
      fast_rate = 1'b0;
      repeat (20) @(negedge clk);
      run_pkt(2'd0, 8'h7E, SLOW_BIT);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule